// File: doc/BRIEF.md
# Floating-Point Error Gating Logic

This block sits at the issue point of a floating-point unit. For each issued instruction it decides whether the instruction goes ahead or freezes. An instruction freezes when the legacy error mode is selected, an unmasked numeric error is pending, and the external ignore-error pin is not in force. The block then holds the freeze until an external interrupt is signalled. A set of control instructions still runs while an error is pending, so that software can inspect and clear the error state. The instruction decoder supplies a one-hot class vector, and a parameter mask marks which classes belong to that control group.

The ignore-error pin is active low and asynchronous, so it passes through two flops before it is used. In dual-processor configuration the pin is treated as deasserted. When the native reporting mode is selected, the pin is disregarded and the instruction proceeds; error reporting then happens elsewhere.

Top module: `fpu_err_gate`

## Requirements
- R1: When `err_sum` is 0 and the block is not frozen, every issued instruction gets `proceed` = 1 and `freeze` = 0, whatever `ne_mode` and `ign_n` are.
- R2: When `ne_mode` is 1 and the block is not frozen, an issue never produces `freeze`; it produces `proceed`, with the ignore pin in either state.
- R3: When `ne_mode` is 0, `err_sum` is 1 and the synchronized ignore pin is asserted (low), issued instructions of any class get `proceed`.
- R4: `ign_n` goes through a two-flop synchronizer. A new pin level reaches the decision only after the second rising clock edge following its change. Between the first and second edge, the old level still governs.
- R5: With `ne_mode` 0, `err_sum` 1 and the ignore pin not asserted, an issue whose one-hot `cls` bit lies in `CTRL_MASK` gets `proceed`. By default classes 0 to 8 are the control group (mask 0x01FF of 16 classes).
- R6: Under the same conditions, an issue whose class lies outside the mask gets a single-cycle `freeze` pulse and no `proceed`.
- R7: `frz_active` rises in the cycle after a `freeze` pulse. It stays high until an `intr_arr` strobe is seen, and it is low in the cycle after that strobe.
- R8: While `frz_active` is high, issues produce neither `proceed` nor `freeze`.
- R9: When `dual_cfg` is 1, the ignore pin is treated as deasserted, so a class outside the mask freezes even with `ign_n` low.
- R10: An `intr_arr` strobe while not frozen has no effect. An `intr_arr` strobe in the same cycle as a `freeze` pulse does not cancel it, so `frz_active` still rises.
- R11: After reset, `frz_active` is 0, the synchronizer holds the deasserted level, and with no issue both `proceed` and `freeze` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ne_mode | input | 1 | Native error-reporting mode select |
| ign_n | input | 1 | Asynchronous active-low ignore-error pin |
| dual_cfg | input | 1 | Dual-processor configuration flag |
| err_sum | input | 1 | Pending unmasked error summary |
| issue | input | 1 | Instruction issue strobe |
| cls | input | N_CLS | One-hot decoded instruction class |
| intr_arr | input | 1 | External interrupt arrival strobe |
| proceed | output | 1 | Issued instruction may execute |
| freeze | output | 1 | Issued instruction halts; freeze begins |
| frz_active | output | 1 | Freeze state in force |

## Verification
Two events can fall in the same cycle: the freeze decision for an issued non-control instruction, and the interrupt strobe that ends a freeze. The bench provokes this by raising `issue` with a class outside the mask and `intr_arr` together in one cycle, with no freeze in force. It expects the `freeze` pulse in that cycle and `frz_active` high in the next, because the strobe only ends a freeze that already exists. A later lone strobe must then clear the state.

// File: rtl/fpu_err_gate.sv
module fpu_err_gate #(
  parameter int N_CLS = 16,
  parameter logic [N_CLS-1:0] CTRL_MASK = N_CLS'(16'h01FF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ne_mode,
  input  logic             ign_n,
  input  logic             dual_cfg,
  input  logic             err_sum,
  input  logic             issue,
  input  logic [N_CLS-1:0] cls,
  input  logic             intr_arr,
  output logic             proceed,
  output logic             freeze,
  output logic             frz_active
);

  logic ign_s1, ign_s2;
  logic ign_eff, is_ctrl, stall_cond, live_issue;
  logic frz_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ign_s1 <= 1'b1;
      ign_s2 <= 1'b1;
    end else begin
      ign_s1 <= ign_n;
      ign_s2 <= ign_s1;
    end
  end

  assign ign_eff    = ~ign_s2 & ~dual_cfg;
  assign is_ctrl    = |(cls & CTRL_MASK);
  assign live_issue = issue & ~frz_q;
  assign stall_cond = err_sum & ~ne_mode & ~ign_eff & ~is_ctrl;

  assign freeze     = live_issue & stall_cond;
  assign proceed    = live_issue & ~stall_cond;
  assign frz_active = frz_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frz_q <= 1'b0;
    else        frz_q <= freeze | (frz_q & ~intr_arr);
  end

  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(proceed && freeze));
  p_noerr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !err_sum && !frz_active) |-> proceed);
  p_native_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && ne_mode && !frz_active) |-> !freeze);
  p_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> frz_active);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_active && !intr_arr) |=> frz_active);
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_active && intr_arr) |=> !frz_active);
  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frz_active |-> (!proceed && !freeze));
  p_dual_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_cfg && issue && !frz_active && !ne_mode && err_sum && !(|(cls & CTRL_MASK))) |-> freeze);
  p_cls_r5: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> $onehot0(cls));

endmodule

// File: tb/sim_fpu_err_gate.sv
module sim_fpu_err_gate;
  logic clk = 0, rst_n = 0;
  logic ne_mode = 0, ign_n = 1, dual_cfg = 0, err_sum = 0, issue = 0, intr_arr = 0;
  logic [15:0] cls = '0;
  logic proceed, freeze, frz_active;
  int checks = 0, errors = 0;
  localparam logic [15:0] C_CTRL = 16'h0008;
  localparam logic [15:0] C_CTRL8 = 16'h0100;
  localparam logic [15:0] C_ARITH = 16'h1000;

  always #4 clk = ~clk;

  fpu_err_gate u0 (.clk(clk), .rst_n(rst_n), .ne_mode(ne_mode), .ign_n(ign_n),
    .dual_cfg(dual_cfg), .err_sum(err_sum), .issue(issue), .cls(cls),
    .intr_arr(intr_arr), .proceed(proceed), .freeze(freeze), .frz_active(frz_active));

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); #1; endtask

  task automatic set_ign(logic v); @(negedge clk); ign_n = v; step(); step(); endtask

  task automatic t_reset();
    step();
    chk("R11 frz_active", frz_active, 0);
    chk("R11 proceed", proceed, 0);
    chk("R11 freeze", freeze, 0);
    @(negedge clk); err_sum = 1; cls = C_ARITH; issue = 1; #1;
    chk("R11 sync deasserted -> freeze", freeze, 1);
    @(negedge clk); issue = 0; err_sum = 0; intr_arr = 1;
    step(); intr_arr = 0;
    chk("R11 cleared", frz_active, 0);
  endtask

  task automatic t_no_err();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); ne_mode = i[0]; ign_n = i[1]; err_sum = 0; cls = C_ARITH; issue = 1; #1;
      chk("R1 proceed", proceed, 1);
      chk("R1 no freeze", freeze, 0);
    end
    @(negedge clk); issue = 0; ne_mode = 0; ign_n = 1; step(); step();
  endtask

  task automatic t_native();
    for (int i = 0; i < 2; i++) begin
      set_ign(i[0]);
      @(negedge clk); ne_mode = 1; err_sum = 1; cls = C_ARITH; issue = 1; #1;
      chk("R2 proceed", proceed, 1);
      chk("R2 no freeze", freeze, 0);
      @(negedge clk); issue = 0; ne_mode = 0; #1;
    end
    set_ign(1);
  endtask

  task automatic t_ignore();
    set_ign(0);
    @(negedge clk); err_sum = 1; cls = C_ARITH; issue = 1; #1;
    chk("R3 arith proceeds", proceed, 1);
    @(negedge clk); cls = C_CTRL; #1;
    chk("R3 ctrl proceeds", proceed, 1);
    @(negedge clk); issue = 0; set_ign(1);
  endtask

  task automatic t_sync();
    @(negedge clk); ign_n = 0; err_sum = 1; cls = C_ARITH; issue = 0;
    step(); issue = 1; #1;
    chk("R4 old level after one edge", freeze, 1);
    issue = 0; #1;
    step(); issue = 1; #1;
    chk("R4 new level after two edges", proceed, 1);
    chk("R4 no freeze", freeze, 0);
    @(negedge clk); issue = 0; ign_n = 1; #1;
    step(); issue = 1; #1;
    chk("R4 deassert old level", proceed, 1);
    issue = 0; #1;
    step(); issue = 1; #1;
    chk("R4 deassert new level", freeze, 1);
    @(negedge clk); issue = 0; intr_arr = 1; step(); intr_arr = 0;
    chk("R4 cleanup", frz_active, 0);
  endtask

  task automatic t_whitelist();
    @(negedge clk); err_sum = 1; cls = C_CTRL; issue = 1; #1;
    chk("R5 ctrl class 3 proceeds", proceed, 1);
    @(negedge clk); cls = C_CTRL8; #1;
    chk("R5 ctrl class 8 proceeds", proceed, 1);
    chk("R5 no freeze", freeze, 0);
    @(negedge clk); issue = 0; step();
    chk("R5 not frozen", frz_active, 0);
  endtask

  task automatic t_freeze();
    @(negedge clk); err_sum = 1; cls = 16'h0200; issue = 1; #1;
    chk("R6 freeze pulse", freeze, 1);
    chk("R6 no proceed", proceed, 0);
    chk("R7 not yet active", frz_active, 0);
    @(negedge clk); #1;
    chk("R7 active", frz_active, 1);
    chk("R8 no proceed", proceed, 0);
    chk("R8 no second freeze", freeze, 0);
    @(negedge clk); err_sum = 0; cls = C_CTRL; #1;
    chk("R8 ctrl blocked", proceed, 0);
    @(negedge clk); issue = 0; step(); step();
    chk("R7 held", frz_active, 1);
    @(negedge clk); intr_arr = 1; #1;
    chk("R7 still active in strobe cycle", frz_active, 1);
    step(); intr_arr = 0;
    chk("R7 released", frz_active, 0);
  endtask

  task automatic t_dual();
    set_ign(0);
    @(negedge clk); dual_cfg = 1; err_sum = 1; cls = C_ARITH; issue = 1; #1;
    chk("R9 freeze despite pin", freeze, 1);
    @(negedge clk); issue = 0; intr_arr = 1; step(); intr_arr = 0; dual_cfg = 0;
    set_ign(1);
  endtask

  task automatic t_collide();
    @(negedge clk); intr_arr = 1; err_sum = 0; #1;
    step(); intr_arr = 0;
    chk("R10 lone strobe no effect", frz_active, 0);
    @(negedge clk); err_sum = 1; cls = C_ARITH; issue = 1; intr_arr = 1; #1;
    chk("R10 freeze with strobe", freeze, 1);
    step(); issue = 0; intr_arr = 0;
    chk("R10 freeze wins", frz_active, 1);
    @(negedge clk); intr_arr = 1; step(); intr_arr = 0;
    chk("R10 later release", frz_active, 0);
  endtask

  initial begin
    #(8 * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_no_err();
    t_native();
    t_ignore();
    t_sync();
    t_whitelist();
    t_freeze();
    t_dual();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule